// File: doc/BRIEF.md
# RS-485 Driver Direction Delay Timer

This block generates the direction-control output for an RS-485 line driver that sits behind a UART transmitter. The output goes to its asserted level as soon as the transmitter reports it is busy. It holds that level through every character of a burst. When the transmitter signals that the last stop bit is done and no more data is waiting, the block keeps the driver on for a programmable number of baud bit periods, then releases it.

The hold time comes from a delay input sampled when the final stop bit finishes. It is counted on a one-cycle baud tick, not on system clocks. If a new character starts while the hold is still running, the block abandons the hold. It keeps the driver on and starts again from the next end of burst. A polarity input selects an active-high or active-low output. An enable input forces the output inactive and clears the counter.

Top module: `rs485_dir_timer`

## Requirements
- R1: While `enable_i` is low, `dir_o` is at its inactive level from the next clock edge onward and the hold counter is cleared. After re-enabling with `tx_busy_i` low, `dir_o` stays inactive regardless of baud ticks.
- R2: With `polarity_i`=1 the asserted level of `dir_o` is 1 and the inactive level is 0. With `polarity_i`=0 both levels are inverted. After reset `dir_o` is inactive.
- R3: When enabled and idle, `dir_o` becomes asserted at the clock edge that samples `tx_busy_i` high.
- R4: A `stop_done_i` strobe that arrives while `tx_busy_i` is still high does not start the hold. `dir_o` stays asserted however many baud ticks follow.
- R5: A `stop_done_i` strobe with `tx_busy_i` low captures `delay_i`=d (d>0). `dir_o` stays asserted until the clock edge that samples the d-th `baud_tick_i` pulse after the strobe, and it goes inactive at that edge.
- R6: With `delay_i`=0 at the strobe, `dir_o` goes inactive at the edge that samples `stop_done_i`.
- R7: `tx_busy_i` high during a hold cancels the hold and keeps `dir_o` asserted. The next end-of-burst strobe restarts a full-length hold.
- R8: Only baud ticks that arrive after the strobe count toward the hold. System clock cycles without a tick do not shorten it.
- R9: The largest delay, 255 bit periods, holds `dir_o` asserted through 254 ticks and releases it on the 255th.
- R10: Changing `delay_i` during a hold does not change the length of that hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Direction control enable |
| polarity_i | input | 1 | 1: asserted level high, 0: asserted level low |
| delay_i | input | 8 | Hold time after the last stop bit, in bit periods |
| tx_busy_i | input | 1 | Transmitter is sending or has data queued |
| stop_done_i | input | 1 | One-cycle strobe at the end of a stop bit |
| baud_tick_i | input | 1 | One-cycle strobe per baud bit period |
| dir_o | output | 1 | Driver direction output |

## Verification
The bench targets the off-by-one edges of the hold. A counter that releases a tick early or late shows up on the last tick of a short delay and again at 255. A zero delay handled as 256 or as 1 would leave the driver on after the strobe. The bench also restarts traffic in the middle of a hold. A design that keeps the old count would drop the driver while a character is on the line, or would cut the next hold short. The remaining cases are a stop strobe with data still queued, a delay input rewritten in the middle of a hold, and re-enabling after a disable. Each of these would either release the driver at the wrong moment or leave it stuck on.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_SEND = 2'd1,
    DIR_HOLD = 2'd2
  } dir_state_e;
endpackage

// File: rtl/dir_delay_counter.sv
module dir_delay_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic [W-1:0] count_o,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)                     cnt_d = ZERO;
    else if (load_i)                 cnt_d = load_val_i;
    else if (tick_i && cnt_q != ZERO) cnt_d = cnt_q - ONE;
  end

  assign cnt_en = clear_i | load_i | tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ZERO;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o  = cnt_q;
  assign expire_o = tick_i && !clear_i && !load_i && (cnt_q == ONE);

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == ZERO && !load_i) |=> (cnt_q == ZERO));

  // R1
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == ZERO));
endmodule

// File: rtl/dir_ctrl_fsm.sv
module dir_ctrl_fsm
  import rs485_dir_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         busy_i,
  input  logic         stop_i,
  input  logic         delay_zero_i,
  input  logic [W-1:0] cnt_i,
  input  logic         expire_i,
  output logic         clear_o,
  output logic         load_o,
  output logic         asserted_o
);
  dir_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    clear_o = 1'b0;
    load_o  = 1'b0;
    if (!en_i) begin
      state_d = DIR_IDLE;
      clear_o = 1'b1;
    end else begin
      unique case (state_q)
        DIR_IDLE: begin
          clear_o = 1'b1;
          if (busy_i) state_d = DIR_SEND;
        end
        DIR_SEND: begin
          if (stop_i && !busy_i) begin
            if (delay_zero_i) begin
              state_d = DIR_IDLE;
              clear_o = 1'b1;
            end else begin
              state_d = DIR_HOLD;
              load_o  = 1'b1;
            end
          end
        end
        DIR_HOLD: begin
          if (busy_i) begin
            state_d = DIR_SEND;
            clear_o = 1'b1;
          end else if (expire_i) begin
            state_d = DIR_IDLE;
          end
        end
        default: begin
          state_d = DIR_IDLE;
          clear_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= DIR_IDLE;
    else        state_q <= state_d;
  end

  assign asserted_o = (state_q != DIR_IDLE);

  // R5
  hold_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DIR_HOLD) |-> (cnt_i != '0));

  // R7
  busy_keeps_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && busy_i) |=> (state_q != DIR_IDLE));

  // R6
  zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && state_q == DIR_SEND && stop_i && !busy_i && delay_zero_i)
      |=> (state_q == DIR_IDLE));
endmodule

// File: rtl/rs485_dir_timer.sv
module rs485_dir_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             polarity_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             tx_busy_i,
  input  logic             stop_done_i,
  input  logic             baud_tick_i,
  output logic             dir_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             clear_w, load_w, expire_w, asserted_w;
  logic [DLY_W-1:0] cnt_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dir_ctrl_fsm #(.W(DLY_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .en_i         (enable_i),
    .busy_i       (tx_busy_i),
    .stop_i       (stop_done_i),
    .delay_zero_i (delay_i == '0),
    .cnt_i        (cnt_w),
    .expire_i     (expire_w),
    .clear_o      (clear_w),
    .load_o       (load_w),
    .asserted_o   (asserted_w)
  );

  dir_delay_counter #(.W(DLY_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clear_i    (clear_w),
    .load_i     (load_w),
    .load_val_i (delay_i),
    .tick_i     (baud_tick_i),
    .count_o    (cnt_w),
    .expire_o   (expire_w)
  );

  assign dir_o = polarity_i ? asserted_w : ~asserted_w;

  // R1
  disabled_off_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !enable_i |=> (dir_o == ~polarity_i));

  // R3
  busy_asserts_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (enable_i && tx_busy_i) |=> (dir_o == polarity_i));
endmodule

// File: tb/test_rs485_dir_timer.sv
module test_rs485_dir_timer;
  logic       clk = 1'b0;
  logic       rst_n, enable_i, polarity_i, tx_busy_i, stop_done_i, baud_tick_i;
  logic [7:0] delay_i;
  logic       dir_o;
  int         checks = 0;
  int         fails  = 0;

  always #2 clk = ~clk;

  rs485_dir_timer i_rs485_dir_timer (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .polarity_i(polarity_i),
    .delay_i(delay_i), .tx_busy_i(tx_busy_i), .stop_done_i(stop_done_i),
    .baud_tick_i(baud_tick_i), .dir_o(dir_o));

  task automatic check(string req, logic on);
    logic exp;
    exp = polarity_i ? on : ~on;
    checks++;
    if (dir_o !== exp) begin
      fails++;
      $display("FAIL %s: dir_o=%b expected %b at %0t", req, dir_o, exp, $time);
    end
  endtask

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    baud_tick_i = 1'b1; @(negedge clk);
    baud_tick_i = 1'b0; @(negedge clk);
  endtask

  task automatic start_tx();
    tx_busy_i = 1'b1; @(negedge clk);
  endtask

  task automatic end_tx(int d);
    delay_i = 8'(d); tx_busy_i = 1'b0; stop_done_i = 1'b1; @(negedge clk);
    stop_done_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R2 reset inactive pol1", 1'b0);
    polarity_i = 1'b0; #0;
    check("R2 reset inactive pol0", 1'b0);
    polarity_i = 1'b1;
  endtask

  task automatic t_basic();
    start_tx();
    check("R3 asserted on busy", 1'b1);
    end_tx(3);
    check("R5 held after strobe", 1'b1);
    tick(); tick();
    check("R5 held after 2 of 3 ticks", 1'b1);
    tick();
    check("R5 released on 3rd tick", 1'b0);
  endtask

  task automatic t_zero();
    start_tx();
    end_tx(0);
    check("R6 zero delay releases at strobe", 1'b0);
  endtask

  task automatic t_busy_stop();
    start_tx();
    stop_done_i = 1'b1; delay_i = 8'd1; @(negedge clk); stop_done_i = 1'b0;
    repeat (4) tick();
    check("R4 strobe with busy high ignored", 1'b1);
    end_tx(1);
    tick();
    check("R4 later strobe still releases", 1'b0);
  endtask

  task automatic t_cancel();
    start_tx();
    end_tx(4);
    tick(); tick();
    start_tx();
    tick(); tick(); tick();
    check("R7 busy cancels hold", 1'b1);
    end_tx(4);
    tick(); tick(); tick();
    check("R7 full hold restarted", 1'b1);
    tick();
    check("R7 released after full hold", 1'b0);
  endtask

  task automatic t_ticks_ignored();
    start_tx();
    tick(); tick(); tick();
    end_tx(2);
    tick();
    clocks(40);
    check("R8 clocks without ticks do not count", 1'b1);
    tick();
    check("R8 released on 2nd post-strobe tick", 1'b0);
  endtask

  task automatic t_max();
    start_tx();
    end_tx(255);
    repeat (254) tick();
    check("R9 held through 254 ticks", 1'b1);
    tick();
    check("R9 released on 255th tick", 1'b0);
  endtask

  task automatic t_delay_change();
    start_tx();
    end_tx(2);
    delay_i = 8'd200;
    tick();
    check("R10 held after first tick", 1'b1);
    tick();
    check("R10 captured delay used", 1'b0);
  endtask

  task automatic t_disable();
    start_tx();
    end_tx(5);
    tick();
    enable_i = 1'b0; @(negedge clk);
    check("R1 disabled forces inactive", 1'b0);
    tx_busy_i = 1'b1; @(negedge clk);
    check("R1 busy ignored while disabled", 1'b0);
    tx_busy_i = 1'b0; enable_i = 1'b1; @(negedge clk);
    repeat (6) tick();
    check("R1 counter cleared on re-enable", 1'b0);
  endtask

  task automatic t_polarity_low();
    polarity_i = 1'b0; #0;
    check("R2 inactive high with pol0", 1'b0);
    start_tx();
    check("R2 asserted low with pol0", 1'b1);
    end_tx(1);
    tick();
    check("R2 released high with pol0", 1'b0);
    polarity_i = 1'b1;
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable_i = 1'b1; polarity_i = 1'b1; tx_busy_i = 1'b0;
    stop_done_i = 1'b0; baud_tick_i = 1'b0; delay_i = 8'd0;
    clocks(3);
    t_reset();
    rst_n = 1'b1;
    clocks(4);
    t_basic();
    t_zero();
    t_busy_stop();
    t_cancel();
    t_ticks_ignored();
    t_max();
    t_delay_change();
    t_disable();
    t_polarity_low();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule